// File: doc/BRIEF.md
# CRC-4 Multiframe Search Supervisor

This block watches an E1 receive framer while it hunts for CRC-4 multiframe alignment. It keeps a count of the 8 ms search windows that have expired without a lock. The count returns to zero when CRC-4 alignment is gained, and it is held at zero while CRC-4 operation is switched off. Alongside the count, the block registers the three live "searching" flags of the FAS, CAS and CRC-4 synchronizers. It packs the flags and the count into one real-time status byte.

The internal counter is six bits wide and wraps rather than saturating. Only five of its bits are shown in the status byte: bit 1 is left out, so the visible field advances in coarser steps while its reach still goes past 400 ms. A separate sticky flag reports that the search has run for 50 windows (400 ms), which is the point at which the CRC-4 search should be given up. Reading the status byte clears nothing, and the byte always shows the current state.

Top module: `crc4_search_supervisor`

## Requirements
- R1: While reset (rstN low, asynchronous) is asserted, and after it is released, statusByte is 8'h00 and overLimit is 0 until new inputs arrive.
- R2: With crc4ModeEn high and crc4Locked low, each clock cycle with windowTick high raises the window count by one. A cycle without windowTick leaves the count unchanged.
- R3: A cycle with crc4Locked high sets the window count to zero at the next clock edge.
- R4: While crc4ModeEn is low, the window count is held at zero and windowTick has no effect.
- R5: When a clear condition (crc4Locked high or crc4ModeEn low) and windowTick occur in the same cycle, the clear takes effect and the count becomes zero.
- R6: The window count is 6 bits wide. A tick at count 63 wraps it to 0.
- R7: statusByte bit 0 equals crc4Search, bit 1 equals casSearch and bit 2 equals fasSearch, each as sampled at the previous clock edge.
- R8: statusByte bits 3, 4, 5, 6 and 7 carry count bits 0, 2, 3, 4 and 5 respectively. Count bit 1 is not shown, so a count of 2 shows zero in bits 7:3 and a count of 50 shows 5'b11000.
- R9: overLimit rises in the same cycle that the count first reaches 50. It stays high through later ticks and through a wrap, and it drops to 0 together with the counter clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| windowTick | input | 1 | One-cycle pulse at each expiry of an 8 ms CRC-4 search window |
| crc4Locked | input | 1 | CRC-4 multiframe alignment obtained |
| crc4ModeEn | input | 1 | CRC-4 operation enabled |
| fasSearch | input | 1 | FAS synchronizer is searching |
| casSearch | input | 1 | CAS multiframe synchronizer is searching |
| crc4Search | input | 1 | CRC-4 multiframe synchronizer is searching |
| statusByte | output | 8 | Real-time status: search flags in bits 2:0, visible count bits in 7:3 |
| overLimit | output | 1 | Sticky flag: search has passed the 400 ms limit |

## Verification
The bench builds the block with its default parameters: a 6-bit counter, a limit of 50 windows and the hidden bit at position 1. With these values, stepping the count one tick at a time to 50 and then on to the wrap past 63 takes only a few dozen cycles. The bench therefore drives the real limit and the real wrap, not scaled-down copies of them. It also checks the hidden-bit mapping at counts such as 2, 50 and 63, where dropping or shifting a bit changes the visible field.

// File: rtl/crc4_sup_pkg.sv
package crc4_sup_pkg;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic clr;   // clear counter and over-limit flag
    logic inc;   // advance counter by one window
  } supStrobe_t;

endpackage

// File: rtl/crc4_sup_ctrl.sv
module crc4_sup_ctrl
  import crc4_sup_pkg::*;
(
  input  logic       windowTick,
  input  logic       crc4Locked,
  input  logic       crc4ModeEn,
  output supStrobe_t strobes
);

  logic clearReq;

  // Lock or mode-off forces a clear; a clear takes priority over a tick
  always_comb begin
    clearReq    = crc4Locked | ~crc4ModeEn;
    strobes.clr = clearReq;
    strobes.inc = windowTick & ~clearReq;
  end

endmodule

// File: rtl/crc4_sup_dp.sv
module crc4_sup_dp
  import crc4_sup_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int LIMIT    = 50,
  parameter int HIDE_BIT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  supStrobe_t       strobes,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-2:0] visCnt,
  output logic             overLimit
);

  localparam int VIS_W = CNT_W - 1;
  localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(LIMIT - 1);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cntD;
  logic             overD;

  always_comb begin
    cntD  = cntQ;
    overD = overLimit;
    if (strobes.clr) begin
      cntD  = '0;
      overD = 1'b0;
    end else if (strobes.inc) begin
      cntD = cntQ + ONE;               // wraps naturally
      if (cntQ == LIMIT_M1) overD = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ      <= '0;
      overLimit <= 1'b0;
    end else begin
      cntQ      <= cntD;
      overLimit <= overD;
    end
  end

  // Visible field: every counter bit except HIDE_BIT, in ascending order
  for (genvar i = 0; i < VIS_W; i++) begin : g_vis
    if (i < HIDE_BIT) begin : g_low
      assign visCnt[i] = cntQ[i];
    end else begin : g_high
      assign visCnt[i] = cntQ[i+1];
    end
  end

endmodule

// File: rtl/crc4_sup_pack.sv
module crc4_sup_pack #(
  parameter int VIS_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fasSearch,
  input  logic               casSearch,
  input  logic               crc4Search,
  input  logic [VIS_W-1:0]   visCnt,
  output logic [VIS_W+2:0]   statusByte
);

  logic [2:0] flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= {fasSearch, casSearch, crc4Search};
  end

  assign statusByte = {visCnt, flagQ};

endmodule

// File: rtl/crc4_search_supervisor.sv
module crc4_search_supervisor
  import crc4_sup_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int LIMIT    = 50,
  parameter int HIDE_BIT = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       windowTick,
  input  logic       crc4Locked,
  input  logic       crc4ModeEn,
  input  logic       fasSearch,
  input  logic       casSearch,
  input  logic       crc4Search,
  output logic [7:0] statusByte,
  output logic       overLimit
);

  localparam int VIS_W = CNT_W - 1;

  supStrobe_t       strobes;
  logic [CNT_W-1:0] cntQ;
  logic [VIS_W-1:0] visCnt;

  crc4_sup_ctrl ctrl_i (
    .windowTick (windowTick),
    .crc4Locked (crc4Locked),
    .crc4ModeEn (crc4ModeEn),
    .strobes    (strobes)
  );

  crc4_sup_dp #(
    .CNT_W    (CNT_W),
    .LIMIT    (LIMIT),
    .HIDE_BIT (HIDE_BIT)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cntQ      (cntQ),
    .visCnt    (visCnt),
    .overLimit (overLimit)
  );

  crc4_sup_pack #(
    .VIS_W (VIS_W)
  ) pack_i (
    .clk        (clk),
    .rstN       (rstN),
    .fasSearch  (fasSearch),
    .casSearch  (casSearch),
    .crc4Search (crc4Search),
    .visCnt     (visCnt),
    .statusByte (statusByte)
  );

endmodule

// File: rtl/crc4_sup_checker.sv
module crc4_sup_checker #(
  parameter int CNT_W = 6,
  parameter int LIMIT = 50
) (
  input logic             clk,
  input logic             rstN,
  input logic             windowTick,
  input logic             crc4Locked,
  input logic             crc4ModeEn,
  input logic             fasSearch,
  input logic             casSearch,
  input logic             crc4Search,
  input logic [7:0]       statusByte,
  input logic             overLimit,
  input logic [CNT_W-1:0] cntQ
);

  logic clrIn;
  assign clrIn = crc4Locked | ~crc4ModeEn;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (windowTick && !clrIn) |=> cntQ == CNT_W'($past(cntQ) + CNT_W'(1)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!windowTick && !clrIn) |=> $stable(cntQ));

  assert_lock_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    crc4Locked |=> cntQ == '0);

  assert_mode_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    !crc4ModeEn |=> cntQ == '0);

  assert_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> statusByte[2:0] == $past({fasSearch, casSearch, crc4Search}));

  assert_over_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overLimit) |-> cntQ == CNT_W'(LIMIT));

  assert_over_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    clrIn |=> !overLimit);

endmodule

bind crc4_search_supervisor crc4_sup_checker #(
  .CNT_W (CNT_W),
  .LIMIT (LIMIT)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .windowTick (windowTick),
  .crc4Locked (crc4Locked),
  .crc4ModeEn (crc4ModeEn),
  .fasSearch  (fasSearch),
  .casSearch  (casSearch),
  .crc4Search (crc4Search),
  .statusByte (statusByte),
  .overLimit  (overLimit),
  .cntQ       (cntQ)
);

// File: tb/crc4_search_supervisor_tb_top.sv
module crc4_search_supervisor_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic windowTick = 1'b0, crc4Locked = 1'b0, crc4ModeEn = 1'b0;
  logic fasSearch = 1'b0, casSearch = 1'b0, crc4Search = 1'b0;
  logic [7:0] statusByte;
  logic overLimit;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc4_search_supervisor dut_i (
    .clk (clk), .rstN (rstN), .windowTick (windowTick),
    .crc4Locked (crc4Locked), .crc4ModeEn (crc4ModeEn),
    .fasSearch (fasSearch), .casSearch (casSearch), .crc4Search (crc4Search),
    .statusByte (statusByte), .overLimit (overLimit)
  );

  // Vector: {tick, lock, en, fas, cas, crc4, expCnt[5:0], expOver}
  localparam logic [12:0] VEC [NVEC] = '{
    {6'b101001, 6'd1, 1'b0},  // R2 tick, crc4 searching
    {6'b101010, 6'd2, 1'b0},  // R2 tick, cas searching; R8 count 2 hidden
    {6'b001100, 6'd2, 1'b0},  // R2 no tick holds; R7 fas
    {6'b101111, 6'd3, 1'b0},  // R2
    {6'b101000, 6'd4, 1'b0},  // R2
    {6'b011000, 6'd0, 1'b0},  // R3 lock clears
    {6'b111000, 6'd0, 1'b0},  // R5 lock beats tick
    {6'b101000, 6'd1, 1'b0},  // R2
    {6'b100000, 6'd0, 1'b0},  // R4/R5 mode off beats tick
    {6'b100001, 6'd0, 1'b0},  // R4 tick ignored while off
    {6'b101000, 6'd1, 1'b0},  // R2
    {6'b101000, 6'd2, 1'b0},  // R8
    {6'b101000, 6'd3, 1'b0}   // R8
  };

  function automatic logic [7:0] packStatus(logic [5:0] c, logic f, logic a, logic r);
    return {c[5], c[4], c[3], c[2], c[0], f, a, r};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic t, logic l, logic e, logic f, logic a, logic r);
    @(negedge clk);
    windowTick = t; crc4Locked = l; crc4ModeEn = e;
    fasSearch = f; casSearch = a; crc4Search = r;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 status in reset", statusByte, 8'h00);
    check("R1 over in reset", {7'd0, overLimit}, 8'h00);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 status after release", statusByte, 8'h00);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [12:0] v;
      v = VEC[i];
      apply(v[12], v[11], v[10], v[9], v[8], v[7]);
      check($sformatf("R2/R3/R4/R5/R7/R8 vec %0d status", i), statusByte,
            packStatus(v[6:1], v[9], v[8], v[7]));
      check($sformatf("R9 vec %0d over", i), {7'd0, overLimit}, {7'd0, v[0]});
    end

    // Run up to the limit: R9, R8
    apply(0, 1, 1, 0, 0, 0);
    check("R3 clear before run", statusByte, 8'h00);
    for (int n = 1; n <= 49; n++) apply(1, 0, 1, 0, 0, 0);
    check("R8 count 49", statusByte, packStatus(6'd49, 0, 0, 0));
    check("R9 not over at 49", {7'd0, overLimit}, 8'h00);
    apply(1, 0, 1, 0, 0, 0);
    check("R8 count 50 field", statusByte, 8'hC0);
    check("R9 over at 50", {7'd0, overLimit}, 8'h01);
    for (int n = 51; n <= 63; n++) apply(1, 0, 1, 0, 0, 0);
    check("R8 count 63", statusByte, 8'hF8);
    apply(1, 0, 1, 0, 0, 0);
    check("R6 wrap to 0", statusByte, 8'h00);
    check("R9 sticky after wrap", {7'd0, overLimit}, 8'h01);
    apply(1, 0, 1, 0, 0, 0);
    check("R6 count after wrap", statusByte, packStatus(6'd1, 0, 0, 0));
    apply(0, 0, 0, 0, 0, 0);
    check("R9 cleared by mode off", {7'd0, overLimit}, 8'h00);
    check("R4 count zero", statusByte, 8'h00);

    // Mid-run reset: R1
    apply(1, 0, 1, 1, 1, 1);
    apply(1, 0, 1, 1, 1, 1);
    check("R7 all flags", statusByte, packStatus(6'd2, 1, 1, 1));
    @(negedge clk); rstN = 1'b0;
    #1;
    check("R1 async reset status", statusByte, 8'h00);
    @(negedge clk); rstN = 1'b1;
    windowTick = 1'b0; fasSearch = 1'b0; casSearch = 1'b0; crc4Search = 1'b0;
    @(posedge clk); #1;
    check("R1 after second release", statusByte, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule